// File: doc/BRIEF.md
# Fractional Pixel Clock Divider

This block derives a pixel clock from one of two input tick streams. Both streams live in one clock domain: `bus_tick` marks cycles of the internal bus clock and `disp_tick` marks cycles of an external display clock. A control bit selects which stream drives the divider. The divisor is a fixed-point number with four fraction bits. A phase accumulator spreads the fraction over successive output periods, so their average length equals the programmed divisor exactly. Within each output period, a rise position and a fall position are given in half-input-cycle units. Together they shape the duty cycle of the pixel clock level.

Software writes three registers through a simple write port. The divisor and the edge positions are staged and only take effect at the start of the next output period. The source select and the output inversion take effect at once. The block produces a one-cycle strobe at the start of each pixel clock period and a level output that follows the programmed waveform.

Top module: `pix_clk_div`

## Requirements
- R1: After reset the divisor is 1.0 (period register value 0x010), the rise position is 0, the fall position is 1, the bus tick stream is selected, inversion is off, and both `pix_stb` and `pix_lvl` are low until the first selected tick.
- R2: With an integer divisor D (period register D<<4, D from 1 to 255), `pix_stb` pulses once every D selected ticks.
- R3: The period register is written at address 0, in bits 11:0, with the integer part in 11:4 and the fraction in 3:0. At each period start, the fraction is added to a 4-bit accumulator that starts at 0 after reset. The new period lasts the integer part plus the carry out of that addition, counted in selected ticks.
- R4: An integer part of 0 is treated as 1.
- R5: The edge register is written at address 1, with the fall position in bits 24:16 and the rise position in bits 8:0, both in half-input-cycle units. For the k-th selected tick of a period (k from 0), the raw level is high exactly when 2k >= rise and 2k < fall.
- R6: Rise 0 with fall equal to the divisor in half cycles gives high for the first ceil(D/2) ticks of an integer period D.
- R7: The control register is written at address 2. Bit 0 = 1 selects `disp_tick` and bit 0 = 0 selects `bus_tick`. Ticks on the unselected stream have no effect.
- R8: Bit 1 of the control register inverts `pix_lvl`, starting from the cycle after the write.
- R9: A write to the period or edge register does not change the current output period. The new value applies from the next period start on.
- R10: Outputs change only on a clock in which a selected tick is present. `pix_stb` is high for exactly that one cycle at a period start, and the raw level holds between ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; both tick streams are synchronous to it |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_tick | input | 1 | One cycle of the internal bus clock source |
| disp_tick | input | 1 | One cycle of the external display clock source |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 period, 1 edges, 2 control |
| cfg_wdata | input | 32 | Register write data |
| pix_stb | output | 1 | One-cycle pulse on the first tick of each pixel clock period |
| pix_lvl | output | 1 | Pixel clock level after optional inversion |

## Verification
A wrong tick counter or period length shows on `pix_stb` at the very next period start, as a strobe one tick early or late. A faulty fraction accumulator shows within sixteen periods as a wrong pattern of short and long periods. Errors in the staged edge values or in the comparison logic show on `pix_lvl` within one period of the write that exposes them, and inversion errors show one cycle after the control write. The bench compares both outputs on every cycle against a model. That model is built from the requirements and runs under directed patterns and seeded random ticks and writes.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
   typedef enum logic [1:0] {
      ADDR_PERIOD = 2'd0,
      ADDR_EDGES  = 2'd1,
      ADDR_CTRL   = 2'd2
   } pcd_addr_e;

   localparam int CTRL_SRC_BIT = 0;
   localparam int CTRL_INV_BIT = 1;
   localparam int FALL_LSB     = 16;
   localparam int RISE_LSB     = 0;
endpackage

// File: rtl/pcd_regs.sv
module pcd_regs
   import pcd_pkg::*;
#(
   parameter int INT_W  = 8,
   parameter int FRAC_W = 4,
   parameter int EDGE_W = 9
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [1:0]                addr,
   input  logic [31:0]               wdata,
   output logic [INT_W+FRAC_W-1:0]   stg_per,
   output logic [EDGE_W-1:0]         stg_rise,
   output logic [EDGE_W-1:0]         stg_fall,
   output logic                      src_ext,
   output logic                      inv
);
   localparam int PER_W = INT_W + FRAC_W;
   localparam logic [PER_W-1:0]  PER_RST  = PER_W'(1) << FRAC_W;
   localparam logic [EDGE_W-1:0] FALL_RST = EDGE_W'(1);

   generate
      if (PER_W > 16) begin : g_bad_per
         $error("period field wider than 16 bits");
      end
      if (FALL_LSB + EDGE_W > 32 || RISE_LSB + EDGE_W > FALL_LSB) begin : g_bad_edge
         $error("edge fields do not fit the write word");
      end
   endgenerate

   logic unused_wdata;
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stg_per  <= PER_RST;
         stg_rise <= '0;
         stg_fall <= FALL_RST;
         src_ext  <= 1'b0;
         inv      <= 1'b0;
      end else if (we) begin
         case (addr)
            ADDR_PERIOD: stg_per <= wdata[PER_W-1:0];
            ADDR_EDGES: begin
               stg_rise <= wdata[RISE_LSB +: EDGE_W];
               stg_fall <= wdata[FALL_LSB +: EDGE_W];
            end
            ADDR_CTRL: begin
               src_ext <= wdata[CTRL_SRC_BIT];
               inv     <= wdata[CTRL_INV_BIT];
            end
            default: ;
         endcase
      end
   end

   // R8
   ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == ADDR_CTRL) |=> (inv == $past(wdata[CTRL_INV_BIT])));
endmodule

// File: rtl/pcd_phase.sv
module pcd_phase #(
   parameter int INT_W  = 8,
   parameter int FRAC_W = 4,
   parameter int EDGE_W = 9
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      tick,
   input  logic [INT_W+FRAC_W-1:0]   stg_per,
   input  logic [EDGE_W-1:0]         stg_rise,
   input  logic [EDGE_W-1:0]         stg_fall,
   output logic [INT_W:0]            cnt_nxt,
   output logic [EDGE_W-1:0]         rise_nxt,
   output logic [EDGE_W-1:0]         fall_nxt,
   output logic                      start
);
   localparam int PER_W = INT_W + FRAC_W;
   localparam int CNT_W = INT_W + 1;

   logic [CNT_W-1:0]  cnt_q, len_q, len_nxt, len_new, int_raw, int_eff;
   logic [EDGE_W-1:0] rise_q, fall_q;
   logic              last, carry;

   assign last    = (cnt_q == len_q - CNT_W'(1));
   assign int_raw = {1'b0, stg_per[PER_W-1:FRAC_W]};
   assign int_eff = (int_raw == '0) ? CNT_W'(1) : int_raw;

   generate
      if (FRAC_W > 0) begin : g_frac
         logic [FRAC_W-1:0] acc_q;
         logic [FRAC_W:0]   sum;
         assign sum   = {1'b0, acc_q} + {1'b0, stg_per[FRAC_W-1:0]};
         assign carry = sum[FRAC_W];
         always_ff @(posedge clk) begin
            if (!rst_n)             acc_q <= '0;
            else if (tick && last)  acc_q <= sum[FRAC_W-1:0];
         end
      end else begin : g_int
         assign carry = 1'b0;
      end
   endgenerate

   assign len_new = int_eff + CNT_W'(carry);

   always_comb begin
      cnt_nxt  = cnt_q;
      len_nxt  = len_q;
      rise_nxt = rise_q;
      fall_nxt = fall_q;
      start    = 1'b0;
      if (tick) begin
         if (last) begin
            cnt_nxt  = '0;
            len_nxt  = len_new;
            rise_nxt = stg_rise;
            fall_nxt = stg_fall;
            start    = 1'b1;
         end else begin
            cnt_nxt = cnt_q + CNT_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         len_q  <= CNT_W'(1);
         rise_q <= '0;
         fall_q <= EDGE_W'(1);
      end else begin
         cnt_q  <= cnt_nxt;
         len_q  <= len_nxt;
         rise_q <= rise_nxt;
         fall_q <= fall_nxt;
      end
   end

   // R4
   len_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (len_q != '0) && (len_q <= CNT_W'(1 << INT_W)));
   // R2
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < len_q);
   // R10
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt_q) && $stable(len_q));
   // R9
   edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tick && last) |=> $stable(rise_q) && $stable(fall_q));
endmodule

// File: rtl/pcd_wave.sv
module pcd_wave #(
   parameter int INT_W  = 8,
   parameter int EDGE_W = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               start,
   input  logic [INT_W:0]     cnt_nxt,
   input  logic [EDGE_W-1:0]  rise_nxt,
   input  logic [EDGE_W-1:0]  fall_nxt,
   output logic               stb_q,
   output logic               raw_q
);
   localparam int CMP_W = INT_W + 2;

   generate
      if (EDGE_W > CMP_W) begin : g_bad_cmp
         $error("edge field wider than the half-cycle position");
      end
   endgenerate

   logic [CMP_W-1:0] pos2, rise_x, fall_x;
   logic             hi;

   assign pos2   = {cnt_nxt, 1'b0};
   assign rise_x = CMP_W'(rise_nxt);
   assign fall_x = CMP_W'(fall_nxt);
   assign hi     = (pos2 >= rise_x) && (pos2 < fall_x);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stb_q <= 1'b0;
         raw_q <= 1'b0;
      end else begin
         stb_q <= start;
         if (tick) raw_q <= hi;
      end
   end

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> !stb_q && $stable(raw_q));
endmodule

// File: rtl/pix_clk_div.sv
module pix_clk_div #(
   parameter int INT_W  = 8,
   parameter int FRAC_W = 4,
   parameter int EDGE_W = 9
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_tick,
   input  logic        disp_tick,
   input  logic        cfg_we,
   input  logic [1:0]  cfg_addr,
   input  logic [31:0] cfg_wdata,
   output logic        pix_stb,
   output logic        pix_lvl
);
   localparam int PER_W = INT_W + FRAC_W;

   logic [PER_W-1:0]  stg_per;
   logic [EDGE_W-1:0] stg_rise, stg_fall, rise_nxt, fall_nxt;
   logic [INT_W:0]    cnt_nxt;
   logic              src_ext, inv, tick, start, raw;

   assign tick = src_ext ? disp_tick : bus_tick;

   pcd_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W), .EDGE_W(EDGE_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .stg_per(stg_per), .stg_rise(stg_rise), .stg_fall(stg_fall),
      .src_ext(src_ext), .inv(inv)
   );

   pcd_phase #(.INT_W(INT_W), .FRAC_W(FRAC_W), .EDGE_W(EDGE_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .tick(tick), .stg_per(stg_per),
      .stg_rise(stg_rise), .stg_fall(stg_fall), .cnt_nxt(cnt_nxt),
      .rise_nxt(rise_nxt), .fall_nxt(fall_nxt), .start(start)
   );

   pcd_wave #(.INT_W(INT_W), .EDGE_W(EDGE_W)) u_wave (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .cnt_nxt(cnt_nxt),
      .rise_nxt(rise_nxt), .fall_nxt(fall_nxt), .stb_q(pix_stb), .raw_q(raw)
   );

   assign pix_lvl = raw ^ inv;
endmodule

// File: tb/tb_pix_clk_div.sv
module tb_pix_clk_div;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic        rst_n, bus_tick, disp_tick, cfg_we, pix_stb, pix_lvl;
   logic [1:0]  cfg_addr;
   logic [31:0] cfg_wdata;

   pix_clk_div dut (
      .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick), .disp_tick(disp_tick),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .pix_stb(pix_stb), .pix_lvl(pix_lvl)
   );

   int n_vec = 0, n_bad = 0;
   string cur_req = "R1";

   // model state, from the requirements
   int m_sel = 0, m_inv = 0, m_sper = 16, m_srise = 0, m_sfall = 1;
   int m_arise = 0, m_afall = 1, m_acc = 0, m_len = 1, m_cnt = 0, m_raw = 0;
   bit e_stb = 0, e_lvl = 0;

   function automatic bit level_of(int k, int r, int f);
      return (2*k >= r) && (2*k < f);
   endfunction

   task automatic step(input bit bt, input bit dt, input bit we,
                       input logic [1:0] a, input logic [31:0] d);
      int ip, s;
      bit tk;
      @(negedge clk);
      n_vec++;
      if (pix_stb !== e_stb || pix_lvl !== e_lvl) begin
         n_bad++;
         $display("FAIL %s: stb/lvl got %0b/%0b expected %0b/%0b at vector %0d",
                  cur_req, pix_stb, pix_lvl, e_stb, e_lvl, n_vec);
      end
      bus_tick = bt; disp_tick = dt; cfg_we = we; cfg_addr = a; cfg_wdata = d;
      tk = (m_sel != 0) ? dt : bt;
      e_stb = 0;
      if (tk) begin
         if (m_cnt == m_len - 1) begin
            m_cnt = 0;
            ip = (m_sper >> 4) & 255;
            if (ip == 0) ip = 1;
            s = m_acc + (m_sper & 15);
            m_len = ip + (s >> 4);
            m_acc = s & 15;
            m_arise = m_srise; m_afall = m_sfall;
            e_stb = 1;
         end else m_cnt++;
         m_raw = level_of(m_cnt, m_arise, m_afall);
      end
      if (we) begin
         case (a)
            2'd0: m_sper = d & 32'hfff;
            2'd1: begin m_srise = d & 32'h1ff; m_sfall = (d >> 16) & 32'h1ff; end
            2'd2: begin m_sel = d[0]; m_inv = d[1]; end
            default: ;
         endcase
      end
      e_lvl = m_raw[0] ^ m_inv[0];
   endtask

   task automatic run(input int n, input bit bt, input bit dt);
      for (int i = 0; i < n; i++) step(bt, dt, 0, 2'd0, 32'd0);
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d, input bit bt);
      step(bt, 0, 1, a, d);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      rst_n = 0; bus_tick = 0; disp_tick = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;
      // R1: reset state, then divide-by-1.0
      cur_req = "R1";
      run(2, 0, 0);
      run(6, 1, 0);
      // R2: integer divisors
      cur_req = "R2";
      wr(2'd0, 32'h040, 1); wr(2'd1, (32'd4 << 16), 1);
      run(24, 1, 0);
      wr(2'd0, 32'h070, 1); wr(2'd1, (32'd7 << 16), 1);
      run(30, 1, 0);
      // R6: 50% duty with odd and even divisors
      cur_req = "R6";
      wr(2'd0, 32'h050, 1); wr(2'd1, (32'd5 << 16), 1);
      run(25, 1, 0);
      // R3: fractional divisors 2.5 and 3.25
      cur_req = "R3";
      wr(2'd0, 32'h028, 1); wr(2'd1, (32'd2 << 16), 1);
      run(30, 1, 0);
      wr(2'd0, 32'h034, 1); wr(2'd1, (32'd3 << 16), 1);
      run(60, 1, 0);
      // R4: integer part zero
      cur_req = "R4";
      wr(2'd0, 32'h000, 1); wr(2'd1, 32'd0 | (32'd1 << 16), 1);
      run(10, 1, 0);
      wr(2'd0, 32'h008, 1);
      run(16, 1, 0);
      // R5: arbitrary edges, empty and inverted windows
      cur_req = "R5";
      wr(2'd0, 32'h060, 1); wr(2'd1, (32'd9 << 16) | 32'd4, 1);
      run(24, 1, 0);
      wr(2'd1, 32'd0, 1);
      run(14, 1, 0);
      wr(2'd1, (32'd3 << 16) | 32'd8, 1);
      run(14, 1, 0);
      // R9: mid-period writes
      cur_req = "R9";
      wr(2'd0, 32'h080, 1); wr(2'd1, (32'd8 << 16), 1);
      run(11, 1, 0);
      wr(2'd0, 32'h030, 1); run(2, 1, 0); wr(2'd1, (32'd6 << 16) | 32'd2, 1);
      run(20, 1, 0);
      // R7: source select
      cur_req = "R7";
      wr(2'd2, 32'h1, 1);
      run(12, 1, 0);
      run(12, 0, 1);
      run(8, 1, 1);
      wr(2'd2, 32'h0, 0);
      run(10, 0, 1);
      run(10, 1, 0);
      // R8: inversion
      cur_req = "R8";
      wr(2'd2, 32'h2, 0);
      run(12, 1, 0);
      wr(2'd2, 32'h3, 0);
      run(12, 0, 1);
      wr(2'd2, 32'h0, 0);
      run(6, 1, 0);
      // R10: sparse ticks
      cur_req = "R10";
      wr(2'd0, 32'h038, 0); wr(2'd1, (32'd4 << 16) | 32'd1, 0);
      for (int i = 0; i < 200; i++) step(($urandom(7) % 10) < 3, ($urandom % 10) < 5, 0, 2'd0, 32'd0);
      // random mix of ticks and writes
      cur_req = "R5";
      for (int i = 0; i < 4000; i++) begin
         int r;
         r = $urandom % 60;
         if (r == 0)
            step($urandom % 2, $urandom % 2, 1, 2'd0, (($urandom % 12 + (i % 3 == 0 ? 0 : 1)) << 4) | ($urandom % 16));
         else if (r == 1)
            step($urandom % 2, $urandom % 2, 1, 2'd1, (($urandom % 26) << 16) | ($urandom % 26));
         else if (r == 2)
            step($urandom % 2, $urandom % 2, 1, 2'd2, $urandom % 4);
         else
            step(($urandom % 10) < 7, ($urandom % 10) < 7, 0, 2'd0, 32'd0);
      end
      run(1, 0, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule